// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is the combinational logic core of one logic block in a small programmable logic device. It reads 36 input signals and produces 16 macrocell sum outputs and 6 control-term outputs. Every macrocell has its own group of five product terms that are ORed together by fixed wiring. A shared pool of 32 product terms feeds a programmable OR matrix, so any pool term can be added to any macrocell sum. One pool term may feed several sums at once, and a single sum can combine up to 37 terms.

Six further terms drive the macrocell control functions elsewhere in the device. Each of them is configured on its own as either an AND of its selected literals or an OR of them. All configuration is held in one shift chain. The chain is loaded serially before use. After loading, every output is a purely combinational function of the inputs.

Top module: `sop_logic_array`

## Requirements
- R1: An active-low `rst_n` clears every configuration bit asynchronously. With the chain cleared, every `mc_sum` and `ctl_out` bit is 0 for any input.
- R2: On each rising `cfg_clk` with `cfg_en` high, `cfg_din` enters chain bit 9013 and every other bit moves down one place. The first bit of a 9014-bit load therefore lands at bit 0.
- R3: Term t owns chain bits t*72 to t*72+71. Bit t*72+2i connects input i in true form, and bit t*72+2i+1 connects its complement. A product term is the AND of its connected literals. A product term with no connected literal is 0.
- R4: Macrocell m has the dedicated terms 5m to 5m+4. These always reach `mc_sum[m]` through a fixed OR.
- R5: Pool term p is term 80+p. It reaches `mc_sum[m]` only when OR bit 8496+16p+m is 1.
- R6: One pool term may be routed into several macrocell sums at once. A single sum combines up to 37 terms (5 dedicated and 32 pool).
- R7: Control term c is term 112+c. Mode bit 9008+c selects its type: 0 gives an AND of its connected literals, and 1 gives an OR of them. In either mode a control term with no connected literal is 0.
- R8: Once loaded, the outputs follow `in_sig` combinationally with no `cfg_clk` edge in between.
- R9: While `cfg_en` is low, `cfg_din` and `cfg_clk` edges leave the configuration, and so the input-to-output function, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low clear of the configuration chain |
| cfg_en | input | 1 | Shift enable for the chain |
| cfg_din | input | 1 | Serial configuration data |
| in_sig | input | 36 | Array inputs |
| mc_sum | output | 16 | Macrocell sum outputs |
| ctl_out | output | 6 | Control-term outputs |

## Verification
The bench targets the term with no connected literal, in both product and sum mode. A design that reduced an empty AND to 1 would turn every unused term on and drive every sum high. One pool term is routed to three macrocells, and a further one-hot sweep reaches a single macrocell through all 37 of its terms. These two cases expose a routing matrix with its row and column indices swapped, or with the fixed OR truncated. Mixed control-term modes catch an inverted mode bit. A hold phase drives random serial data with the shift enable low, which exposes a chain that shifts without its enable. Random sparse configurations are compared against a model built from the bit layout in the requirements, so any mistake in the field offsets shows up as a miscompare.

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
  parameter int N_IN   = 36,
  parameter int N_MC   = 16,
  parameter int N_DED  = 5,
  parameter int N_POOL = 32,
  parameter int N_CTL  = 6
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_din,
  input  logic [N_IN-1:0]   in_sig,
  output logic [N_MC-1:0]   mc_sum,
  output logic [N_CTL-1:0]  ctl_out
);
  localparam int LIT_W     = 2 * N_IN;
  localparam int N_DT      = N_MC * N_DED;
  localparam int CT_BASE   = N_DT + N_POOL;
  localparam int N_TERM    = CT_BASE + N_CTL;
  localparam int OR_BASE   = N_TERM * LIT_W;
  localparam int MODE_BASE = OR_BASE + N_POOL * N_MC;
  localparam int CFG_W     = MODE_BASE + N_CTL;

  logic [CFG_W-1:0]       cfg_q;
  logic [LIT_W-1:0]       lit;
  logic [N_TERM-1:0]      t_and;
  logic [N_DT-1:0]        ded_pt;
  logic [N_POOL-1:0]      pool_pt;
  logic [N_MC*N_POOL-1:0] or_map;

  always_ff @(posedge cfg_clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= {cfg_din, cfg_q[CFG_W-1:1]};

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   =  in_sig[i];
    assign lit[2*i+1] = ~in_sig[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_and
    logic [LIT_W-1:0] sel;
    assign sel      = cfg_q[t*LIT_W +: LIT_W];
    assign t_and[t] = (|sel) & (&(lit | ~sel));
  end

  assign ded_pt  = t_and[N_DT-1:0];
  assign pool_pt = t_and[N_DT +: N_POOL];

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    for (genvar p = 0; p < N_POOL; p++) begin : g_or
      assign or_map[m*N_POOL+p] = cfg_q[OR_BASE + p*N_MC + m];
    end
    assign mc_sum[m] = (|ded_pt[m*N_DED +: N_DED]) |
                       (|(pool_pt & or_map[m*N_POOL +: N_POOL]));
  end

  for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
    logic [LIT_W-1:0] csel;
    logic             c_or;
    assign csel       = cfg_q[(CT_BASE+c)*LIT_W +: LIT_W];
    assign c_or       = |(lit & csel);
    assign ctl_out[c] = cfg_q[MODE_BASE+c] ? c_or : t_and[CT_BASE+c];
  end
endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk #(
  parameter int N_IN   = 36,
  parameter int N_MC   = 16,
  parameter int N_DED  = 5,
  parameter int N_POOL = 32,
  parameter int N_CTL  = 6,
  parameter int CFG_W  = 9014
) (
  input logic                   cfg_clk,
  input logic                   rst_n,
  input logic                   cfg_en,
  input logic                   cfg_din,
  input logic [N_IN-1:0]        in_sig,
  input logic [N_MC-1:0]        mc_sum,
  input logic [N_CTL-1:0]       ctl_out,
  input logic [CFG_W-1:0]       cfg_q,
  input logic [N_MC*N_DED-1:0]  ded_pt,
  input logic [N_POOL-1:0]      pool_pt,
  input logic [N_MC*N_POOL-1:0] or_map
);
  assert_reset_clears_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cfg_q == '0));

  assert_empty_quiet_R1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_q == '0) |-> (mc_sum == '0 && ctl_out == '0));

  assert_shift_entry_R2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_en |=> (cfg_q[CFG_W-1] == $past(cfg_din)));

  assert_hold_stable_R9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!$past(cfg_en) && $stable(in_sig)) |-> ($stable(mc_sum) && $stable(ctl_out)));

  for (genvar m = 0; m < N_MC; m++) begin : g_chk
    assert_dedicated_R4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (|ded_pt[m*N_DED +: N_DED]) |-> mc_sum[m]);
    assert_pool_route_R5: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      (|(pool_pt & or_map[m*N_POOL +: N_POOL])) |-> mc_sum[m]);
    assert_sum_sources_R6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      mc_sum[m] |-> ((|ded_pt[m*N_DED +: N_DED]) || (|(pool_pt & or_map[m*N_POOL +: N_POOL]))));
  end
endmodule

bind sop_logic_array sop_logic_array_chk #(
  .N_IN(N_IN), .N_MC(N_MC), .N_DED(N_DED), .N_POOL(N_POOL), .N_CTL(N_CTL), .CFG_W(CFG_W)
) u_chk (
  .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
  .in_sig(in_sig), .mc_sum(mc_sum), .ctl_out(ctl_out), .cfg_q(cfg_q),
  .ded_pt(ded_pt), .pool_pt(pool_pt), .or_map(or_map)
);

// File: tb/sim_sop_logic_array.sv
`timescale 1ns/1ps
module sim_sop_logic_array;
  localparam int W = 9014;
  localparam int ORB = 8496;
  localparam int MDB = 9008;

  logic        cfg_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic        cfg_din = 1'b0;
  logic [35:0] in_sig = '0;
  logic [15:0] mc_sum;
  logic [5:0]  ctl_out;

  logic [W-1:0] img;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 cfg_clk = ~cfg_clk;

  sop_logic_array u0 (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .in_sig(in_sig), .mc_sum(mc_sum), .ctl_out(ctl_out)
  );

  function automatic logic [21:0] model(input logic [35:0] x);
    logic [71:0]  l;
    logic [71:0]  s;
    logic [117:0] pa;
    logic [21:0]  r;
    for (int i = 0; i < 36; i++) begin
      l[2*i] = x[i];
      l[2*i+1] = ~x[i];
    end
    for (int t = 0; t < 118; t++) begin
      s = img[t*72 +: 72];
      pa[t] = (s != '0) && ((s & ~l) == '0);
    end
    for (int m = 0; m < 16; m++) begin
      r[m] = |pa[m*5 +: 5];
      for (int p = 0; p < 32; p++)
        if (pa[80+p] && img[ORB + p*16 + m]) r[m] = 1'b1;
    end
    for (int c = 0; c < 6; c++) begin
      s = img[(112+c)*72 +: 72];
      r[16+c] = img[MDB+c] ? |(s & l) : pa[112+c];
    end
    return r;
  endfunction

  task automatic connect(input int t, input int i, input bit neg);
    img[t*72 + 2*i + neg] = 1'b1;
  endtask

  task automatic route(input int p, input int m);
    img[ORB + p*16 + m] = 1'b1;
  endtask

  task automatic load_img();
    for (int b = 0; b < W; b++) begin
      @(negedge cfg_clk);
      cfg_en = 1'b1;
      cfg_din = img[b];
    end
    @(negedge cfg_clk);
    cfg_en = 1'b0;
    cfg_din = 1'b0;
  endtask

  task automatic apply(input logic [35:0] x, input string req);
    logic [21:0] exp_v;
    @(negedge cfg_clk);
    in_sig = x;
    #2;
    exp_v = model(x);
    n_chk++;
    if ({ctl_out, mc_sum} !== exp_v) begin
      n_fail++;
      $display("FAIL %s in=%h actual=%h expected=%h", req, x, {ctl_out, mc_sum}, exp_v);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    img = '0;
    repeat (3) @(negedge cfg_clk);
    for (int k = 0; k < 4; k++) apply({$urandom, $urandom}, "R1 reset");
    rst_n = 1'b1;
    apply('1, "R1 reset");
  endtask

  task automatic t_empty_sum_mode();
    img = '0;
    for (int c = 0; c < 6; c++) img[MDB+c] = 1'b1;
    load_img();
    apply('0, "R7 empty sum");
    apply('1, "R7 empty sum");
    apply(36'h5_5555_5555, "R3 empty product");
  endtask

  task automatic t_dedicated();
    img = '0;
    connect(3*5+2, 5, 1'b0);
    connect(3*5+2, 7, 1'b1);
    connect(9*5+4, 20, 1'b0);
    load_img();
    for (int k = 0; k < 4; k++) apply(36'(k[0]) << 5 | 36'(k[1]) << 7, "R4 dedicated");
    apply(36'h1 << 20, "R4 dedicated");
    apply(36'hF_FFFF_FFFF, "R3 complement literal");
  endtask

  task automatic t_shared();
    img = '0;
    connect(80+7, 0, 1'b0);
    connect(80+7, 35, 1'b0);
    route(7, 0); route(7, 9); route(7, 15);
    connect(80+20, 12, 1'b1);
    load_img();
    apply(36'h8_0000_0001, "R6 shared term");
    apply(36'h0_0000_0001, "R5 pool gated");
    apply(36'h8_0000_1000, "R5 unrouted pool");
    apply('0, "R5 unrouted pool");
  endtask

  task automatic t_wide();
    img = '0;
    for (int j = 0; j < 5; j++) connect(12*5+j, j, 1'b0);
    for (int p = 0; p < 31; p++) begin
      connect(80+p, 5+p, 1'b0);
      route(p, 12);
    end
    connect(80+31, 0, 1'b0);
    connect(80+31, 1, 1'b0);
    route(31, 12);
    load_img();
    apply('0, "R6 wide sum");
    for (int i = 0; i < 36; i++) apply(36'h1 << i, "R6 wide sum");
    apply(36'h3, "R6 wide sum");
  endtask

  task automatic t_ctl();
    img = '0;
    for (int c = 0; c < 6; c++) begin
      connect(112+c, c, 1'b0);
      connect(112+c, 10+c, 1'b1);
      img[MDB+c] = c[0];
    end
    load_img();
    apply('0, "R7 ctl modes");
    apply(36'h3F, "R7 ctl modes");
    apply(36'hFC3F, "R7 ctl modes");
    apply(36'h15, "R7 ctl modes");
  endtask

  task automatic t_random(input int seedset);
    img = '0;
    for (int t = 0; t < 118; t++) begin
      int nl;
      nl = int'($urandom % 4);
      for (int k = 0; k < nl; k++) connect(t, int'($urandom % 36), bit'($urandom % 2));
    end
    for (int b = ORB; b < MDB; b++) img[b] = (($urandom % 4) == 0);
    for (int c = 0; c < 6; c++) img[MDB+c] = bit'($urandom % 2);
    load_img();
    for (int k = 0; k < 120; k++) apply({$urandom, $urandom}, $sformatf("R3 R5 R7 random %0d", seedset));
  endtask

  task automatic t_hold();
    for (int k = 0; k < 60; k++) begin
      @(negedge cfg_clk);
      cfg_en = 1'b0;
      cfg_din = bit'($urandom % 2);
    end
    for (int k = 0; k < 40; k++) apply({$urandom, $urandom}, "R9 hold");
  endtask

  task automatic t_comb();
    for (int k = 0; k < 10; k++) begin
      logic [35:0] x;
      x = {$urandom, $urandom};
      @(posedge cfg_clk);
      #3;
      in_sig = x;
      #1;
      n_chk++;
      if ({ctl_out, mc_sum} !== model(x)) begin
        n_fail++;
        $display("FAIL R8 in=%h actual=%h expected=%h", x, {ctl_out, mc_sum}, model(x));
      end
    end
  endtask

  initial begin
    t_reset();
    t_empty_sum_mode();
    t_dedicated();
    t_shared();
    t_wide();
    t_ctl();
    for (int s = 0; s < 3; s++) t_random(s);
    t_hold();
    t_comb();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule